// File: doc/BRIEF.md
# Dual-Pointer Circular Window Address Generator

This block produces the byte addresses for a host data window into a 24 KB buffer memory covering 0000h through 5FFFh. It keeps two pointers, one for host reads and one for host writes. Each moves forward by one whenever its own data-port access strobe is seen. The host loads the pointers and two boundary registers through a 16-bit register-write port with a 2-bit select. The two boundary registers are a region start and a region end. The current value of every register is presented on the outputs.

The wrap behaviour follows the boundaries. When a pointer sits exactly on the region end address, its next advance takes it to the region start address. Otherwise a pointer at the top of memory (5FFFh) rolls over to 0000h, and any other pointer simply increments. This one rule covers three set-ups:

- With end above start, it forms a circular region.
- With start above end, it forms an exclusion zone that the pointers jump over.
- With both boundaries beyond 5FFFh, the region is switched off and the pointers wrap over the whole memory.

The memory array, the serial host link and any packet handling sit outside this block.

Top module: `circ_win_addr`

## Requirements
- R1: The region start register always holds an even value: bit 0 of whatever the host writes is stored as 0.
- R2: The region end register always holds an odd value: bit 0 of whatever the host writes is stored as 1.
- R3: A pointer at 5FFFh that does not equal the region end advances to 0000h. A pointer that is at neither 5FFFh nor the region end advances to its value plus one.
- R4: With region end above region start, a pointer equal to the end advances to the start. A pointer outside the region advances normally and wraps from 5FFFh to 0000h.
- R5: With region start above region end, a pointer equal to the end advances directly to the start, skipping every address in between. A pointer at 5FFFh still wraps to 0000h.
- R6: With the boundaries set to 6000h and 6001h, no pointer ever jumps. Pointers pass normally through every address and wrap from 5FFFh to 0000h.
- R7: The read access strobe advances only the read pointer, and the write access strobe advances only the write pointer. When both strobes are high in one cycle, both pointers advance.
- R8: A host write to a pointer loads the written value on the next clock edge. If the same pointer's access strobe is high in that cycle, the load takes priority and the increment is dropped.
- R9: While synchronous reset is high, both pointers and the region start become 0000h, and the region end becomes 5FFFh.
- R10: The register select codes are: 0 for the read pointer, 1 for the write pointer, 2 for the region start and 3 for the region end. A written value appears on the matching output one clock after the write, and the other registers are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Host register write strobe |
| regSel | input | 2 | Register select (0 read ptr, 1 write ptr, 2 start, 3 end) |
| regWrData | input | 16 | Value written to the selected register |
| rdAccess | input | 1 | Host read of the data window; advances the read pointer |
| wrAccess | input | 1 | Host write of the data window; advances the write pointer |
| rdAddr | output | 16 | Current read pointer |
| wrAddr | output | 16 | Current write pointer |
| regionStart | output | 16 | Region start register value |
| regionEnd | output | 16 | Region end register value |

## Verification
Two events can collide in one cycle. The first is a host load of a pointer together with that pointer's access strobe. The second is the pair of read and write access strobes firing together. The bench provokes the first by holding the read strobe high during a read-pointer write. It then expects exactly the loaded value, with no added increment. It provokes the second by raising both strobes at once, and expects each pointer to move by one under its own wrap rule while neither pointer disturbs the other.

// File: rtl/circ_win_pkg.sv
`timescale 1ns/1ps
package circ_win_pkg;

  typedef enum logic [1:0] {
    SEL_RD_PTR = 2'd0,
    SEL_WR_PTR = 2'd1,
    SEL_START  = 2'd2,
    SEL_END    = 2'd3
  } regSel_e;

  localparam int NUM_PTRS = 2;
  localparam int PTR_RD   = 0;
  localparam int PTR_WR   = 1;

  typedef struct packed {
    logic [NUM_PTRS-1:0] loadPtr;
    logic [NUM_PTRS-1:0] incPtr;
    logic                loadStart;
    logic                loadEnd;
  } ctrlStrobes_t;

endpackage

// File: rtl/circ_win_next.sv
`timescale 1ns/1ps
module circ_win_next #(
  parameter int               ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] MEM_TOP = 16'h5FFF
) (
  input  logic [ADDR_W-1:0] curPtr,
  input  logic [ADDR_W-1:0] bndStart,
  input  logic [ADDR_W-1:0] bndEnd,
  output logic [ADDR_W-1:0] nextPtr
);

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  // The end boundary is compared first, so it outranks the top-of-memory wrap.
  always_comb begin
    if (curPtr == bndEnd) begin
      nextPtr = bndStart;
    end else if (curPtr == MEM_TOP) begin
      nextPtr = '0;
    end else begin
      nextPtr = curPtr + ONE;
    end
  end

endmodule

// File: rtl/circ_win_ctrl.sv
`timescale 1ns/1ps
module circ_win_ctrl
  import circ_win_pkg::*;
(
  input  logic         regWrEn,
  input  logic [1:0]   regSel,
  input  logic         rdAccess,
  input  logic         wrAccess,
  output ctrlStrobes_t strobes
);

  logic [NUM_PTRS-1:0] accessVec;

  assign accessVec[PTR_RD] = rdAccess;
  assign accessVec[PTR_WR] = wrAccess;

  always_comb begin
    strobes                 = '0;
    strobes.loadPtr[PTR_RD] = regWrEn && (regSel == SEL_RD_PTR);
    strobes.loadPtr[PTR_WR] = regWrEn && (regSel == SEL_WR_PTR);
    strobes.loadStart       = regWrEn && (regSel == SEL_START);
    strobes.loadEnd         = regWrEn && (regSel == SEL_END);
    // A host load of a pointer wins over its increment.
    strobes.incPtr          = accessVec & ~strobes.loadPtr;
  end

endmodule

// File: rtl/circ_win_datapath.sv
`timescale 1ns/1ps
module circ_win_datapath
  import circ_win_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] MEM_TOP = 16'h5FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] ptrOut [NUM_PTRS],
  output logic [ADDR_W-1:0] startOut,
  output logic [ADDR_W-1:0] endOut
);

  logic [ADDR_W-1:0] startQ;
  logic [ADDR_W-1:0] endQ;
  logic [ADDR_W-1:0] ptrQ  [NUM_PTRS];
  logic [ADDR_W-1:0] ptrNx [NUM_PTRS];

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= '0;
      endQ   <= MEM_TOP;
    end else begin
      if (strobes.loadStart) startQ <= {wrData[ADDR_W-1:1], 1'b0};
      if (strobes.loadEnd)   endQ   <= {wrData[ADDR_W-1:1], 1'b1};
    end
  end

  for (genvar gi = 0; gi < NUM_PTRS; gi++) begin : g_ptr
    circ_win_next #(.ADDR_W(ADDR_W), .MEM_TOP(MEM_TOP)) next_i (
      .curPtr  (ptrQ[gi]),
      .bndStart(startQ),
      .bndEnd  (endQ),
      .nextPtr (ptrNx[gi])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        ptrQ[gi] <= '0;
      end else if (strobes.loadPtr[gi]) begin
        ptrQ[gi] <= wrData;
      end else if (strobes.incPtr[gi]) begin
        ptrQ[gi] <= ptrNx[gi];
      end
    end

    assign ptrOut[gi] = ptrQ[gi];

    AST_PTR_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
      strobes.loadPtr[gi] |=> ptrQ[gi] == $past(wrData)) else $error("load lost"); // R8

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!strobes.loadPtr[gi] && !strobes.incPtr[gi]) |=> $stable(ptrQ[gi])) else $error("ptr moved"); // R7

    AST_END_JUMP: assert property (@(posedge clk) disable iff (rst)
      (strobes.incPtr[gi] && ptrQ[gi] == endQ && !strobes.loadStart)
        |=> ptrQ[gi] == $past(startQ)) else $error("no jump at end"); // R5

    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
      (strobes.incPtr[gi] && ptrQ[gi] == MEM_TOP && ptrQ[gi] != endQ)
        |=> ptrQ[gi] == '0) else $error("no wrap at top"); // R3
  end

  assign startOut = startQ;
  assign endOut   = endQ;

  AST_START_EVEN: assert property (@(posedge clk) disable iff (rst)
    !startQ[0]) else $error("start odd"); // R1

  AST_END_ODD: assert property (@(posedge clk) disable iff (rst)
    endQ[0]) else $error("end even"); // R2

endmodule

// File: rtl/circ_win_addr.sv
`timescale 1ns/1ps
module circ_win_addr
  import circ_win_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] MEM_TOP = 16'h5FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              rdAccess,
  input  logic              wrAccess,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] regionStart,
  output logic [ADDR_W-1:0] regionEnd
);

  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] ptrOut [NUM_PTRS];

  circ_win_ctrl ctrl_i (
    .regWrEn (regWrEn),
    .regSel  (regSel),
    .rdAccess(rdAccess),
    .wrAccess(wrAccess),
    .strobes (strobes)
  );

  circ_win_datapath #(.ADDR_W(ADDR_W), .MEM_TOP(MEM_TOP)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (regWrData),
    .ptrOut  (ptrOut),
    .startOut(regionStart),
    .endOut  (regionEnd)
  );

  assign rdAddr = ptrOut[PTR_RD];
  assign wrAddr = ptrOut[PTR_WR];

endmodule

// File: tb/circ_win_addr_tb.sv
`timescale 1ns/1ps
module circ_win_addr_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic        rdAccess = 1'b0;
  logic        wrAccess = 1'b0;
  logic [15:0] rdAddr, wrAddr, regionStart, regionEnd;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  circ_win_addr dut_i (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .rdAccess(rdAccess), .wrAccess(wrAccess),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .regionStart(regionStart),
    .regionEnd(regionEnd)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, result is registered at the next posedge, sample at following negedge.
  task automatic regWrite(input logic [1:0] sel, input logic [15:0] data);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic step(input bit rd, input bit wr);
    rdAccess = rd; wrAccess = wr;
    @(negedge clk);
    rdAccess = 1'b0; wrAccess = 1'b0;
  endtask

  task automatic testReset();
    check("R9 rd", rdAddr, 16'h0000);
    check("R9 wr", wrAddr, 16'h0000);
    check("R9 start", regionStart, 16'h0000);
    check("R9 end", regionEnd, 16'h5FFF);
  endtask

  task automatic testAlign();
    regWrite(2'd2, 16'h1235);
    check("R1 start even", regionStart, 16'h1234);
    regWrite(2'd3, 16'h2000);
    check("R2 end odd", regionEnd, 16'h2001);
    check("R10 start untouched by end write", regionStart, 16'h1234);
    regWrite(2'd0, 16'h0ABC);
    check("R10 rd ptr select", rdAddr, 16'h0ABC);
    check("R10 wr ptr untouched", wrAddr, 16'h0000);
  endtask

  task automatic testNormalRegion();
    regWrite(2'd2, 16'h1000);
    regWrite(2'd3, 16'h10FF);
    regWrite(2'd0, 16'h10FE);
    step(1, 0);
    check("R3 plain increment", rdAddr, 16'h10FF);
    step(1, 0);
    check("R4 end wraps to start", rdAddr, 16'h1000);
    regWrite(2'd1, 16'h5FFE);
    step(0, 1);
    check("R4 outside region", wrAddr, 16'h5FFF);
    step(0, 1);
    check("R4 R3 top wraps to zero", wrAddr, 16'h0000);
  endtask

  task automatic testExclusion();
    regWrite(2'd2, 16'h3000);
    regWrite(2'd3, 16'h0FFF);
    regWrite(2'd0, 16'h0FFE);
    step(1, 0);
    check("R5 approach end", rdAddr, 16'h0FFF);
    step(1, 0);
    check("R5 skip to start", rdAddr, 16'h3000);
    regWrite(2'd1, 16'h5FFF);
    step(0, 1);
    check("R5 top still wraps", wrAddr, 16'h0000);
  endtask

  task automatic testDisabled();
    regWrite(2'd2, 16'h6000);
    regWrite(2'd3, 16'h6001);
    regWrite(2'd0, 16'h5FFF);
    regWrite(2'd1, 16'h0FFF);
    step(1, 1);
    check("R6 rd full wrap", rdAddr, 16'h0000);
    check("R6 wr no jump", wrAddr, 16'h1000);
  endtask

  task automatic testIndependence();
    regWrite(2'd0, 16'h0100);
    regWrite(2'd1, 16'h0200);
    step(1, 0);
    check("R7 rd advances", rdAddr, 16'h0101);
    check("R7 wr holds", wrAddr, 16'h0200);
    step(0, 1);
    check("R7 rd holds", rdAddr, 16'h0101);
    check("R7 wr advances", wrAddr, 16'h0201);
    step(1, 1);
    check("R7 both rd", rdAddr, 16'h0102);
    check("R7 both wr", wrAddr, 16'h0202);
  endtask

  task automatic testLoadPriority();
    rdAccess = 1'b1; wrAccess = 1'b1;
    regWrEn = 1'b1; regSel = 2'd0; regWrData = 16'h4444;
    @(negedge clk);
    regWrEn = 1'b0; rdAccess = 1'b0; wrAccess = 1'b0;
    check("R8 load beats increment", rdAddr, 16'h4444);
    check("R8 other ptr still advances", wrAddr, 16'h0203);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testAlign();
    testNormalRegion();
    testExclusion();
    testDisabled();
    testIndependence();
    testLoadPriority();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    testReset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule